// File: doc/BRIEF.md
# Double-Buffered Serial Synthesizer Loader

This block takes a three-wire serial programming stream and turns it into the control register banks of a frequency synthesizer. The three wires are a serial clock, a strobe and a data line. While the strobe is low, each rising serial clock edge shifts one data bit into a 24-bit shift register, most significant bit first. When the strobe rises, the address at the top of the word picks a destination, and the payload is written into the matching working registers. The register banks are the main divider ratio, the compensation DAC code, the reference and auxiliary ratios, the enable bits and a test field.

The compensation DAC code is double-buffered. The B word writes it into a hidden staging register, and the code reaches its output only when an A word commits. At that commit it moves out together with the new main divider ratio, on the same clock, so the divider ratio and its compensation always change as a pair. A full setup is sent as C, then B, then A. A D word carries test settings.

All three serial wires are sampled into the system clock domain through two-flop synchronizers. Every output is a register in that domain, and all fields of one word change on a single clock edge.

Top module: `ser_synth_loader`

## Requirements
- R1: After reset, every output (main_div, comp_code, ref_div, aux_div, main_en, aux_en, test_cfg) is zero, and the hidden staging register is zero.
- R2: While ser_stb is low, each rising edge of ser_clk shifts ser_dat into the 24-bit shift register, most significant bit first. The word committed is made of the last 24 accepted bits, with the first bit sent ending up in bit 23.
- R3: A rising edge of ser_clk while ser_stb is high is ignored and leaves the shift register unchanged. This also holds when it arrives in the same system clock cycle in which the rise of ser_stb is first seen.
- R4: A word commits on the rising edge of ser_stb. If ser_stb goes high between two clk edges, the outputs take their new values on the third rising clk edge after that point, and all fields of the word change on that same edge. Without a strobe rise, no output changes.
- R5: Word bits 23:22 = 10 (word C) load ref_div from bits 21:12 and aux_div from bits 11:0.
- R6: Word bits 23:22 = 01 (word B) load main_en from bit 13 and aux_en from bit 12 at once. Bits 21:14 go only into the staging register, and comp_code stays unchanged.
- R7: Word bits 23:22 = 00 (word A) load main_div from bits 21:6 and copy the staging register to comp_code, both on the same clk edge.
- R8: Word bits 23:21 = 110 (word D) load test_cfg from bits 7:0.
- R9: Word bits 23:21 = 111 is an unused code. Committing it changes no output and no staged value.
- R10: The staging register holds its value across an A commit, so a later A word with no B word in between loads the same compensation code again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data shifts on its rising edge |
| ser_stb | input | 1 | Strobe; low to shift, rising edge commits the word |
| ser_dat | input | 1 | Serial data, most significant bit first |
| main_div | output | 16 | Active main divider ratio |
| comp_code | output | 8 | Active compensation DAC code |
| ref_div | output | 10 | Reference divider ratio |
| aux_div | output | 12 | Auxiliary divider ratio |
| main_en | output | 1 | Main synthesizer enable |
| aux_en | output | 1 | Auxiliary synthesizer enable |
| test_cfg | output | 8 | Test settings field |

## Verification
Two functions can fall in the same system clock cycle: the shift of a serial clock edge, and the commit started by a rising strobe. The bench provokes this by raising ser_clk and ser_stb on the same clk edge as the last bit of a word. The correct outcome is that the bit is dropped, so the committed word is the previous least significant bit followed by the 23 new bits, which decodes as an A word with a known divider value. The other coincidence is inside the A commit itself, where the staged code and the divider ratio must land on the same edge. A reference model that is compared on every clock checks both pairs of fields together.

// File: rtl/ser_synth_loader.sv
`timescale 1ns/1ps
module ser_synth_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_stb,
  input  logic        ser_dat,
  output logic [15:0] main_div,
  output logic [7:0]  comp_code,
  output logic [9:0]  ref_div,
  output logic [11:0] aux_div,
  output logic        main_en,
  output logic        aux_en,
  output logic [7:0]  test_cfg
);
  localparam int WORD_W = 24;
  localparam int TOP    = WORD_W - 1;

  logic [2:0]      ck_q;
  logic [2:0]      sb_q;
  logic [1:0]      dt_q;
  logic [TOP:0]    sreg;
  logic [7:0]      comp_stage;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      sb_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[1:0], ser_clk};
      sb_q <= {sb_q[1:0], ser_stb};
      dt_q <= {dt_q[0], ser_dat};
    end

  logic stb_lvl, stb_rise, shift_en;
  assign stb_lvl  = sb_q[1];
  assign stb_rise = sb_q[1] & ~sb_q[2];
  assign shift_en = ck_q[1] & ~ck_q[2] & ~stb_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sreg <= '0;
    else if (shift_en) sreg <= {sreg[TOP-1:0], dt_q[1]};

  logic sel_a, sel_b, sel_c, sel_d;
  assign sel_a = stb_rise && (sreg[TOP -: 2] == 2'b00);
  assign sel_b = stb_rise && (sreg[TOP -: 2] == 2'b01);
  assign sel_c = stb_rise && (sreg[TOP -: 2] == 2'b10);
  assign sel_d = stb_rise && (sreg[TOP -: 3] == 3'b110);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      main_div   <= '0;
      comp_code  <= '0;
      comp_stage <= '0;
      ref_div    <= '0;
      aux_div    <= '0;
      main_en    <= 1'b0;
      aux_en     <= 1'b0;
      test_cfg   <= '0;
    end else begin
      if (sel_a) begin
        main_div  <= sreg[21:6];
        comp_code <= comp_stage;
      end
      if (sel_b) begin
        comp_stage <= sreg[21:14];
        main_en    <= sreg[13];
        aux_en     <= sreg[12];
      end
      if (sel_c) begin
        ref_div <= sreg[21:12];
        aux_div <= sreg[11:0];
      end
      if (sel_d) test_cfg <= sreg[7:0];
    end
endmodule

// File: rtl/ser_synth_loader_chk.sv
`timescale 1ns/1ps
module ser_synth_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] sreg,
  input logic        stb_rise,
  input logic        stb_lvl,
  input logic        shift_en,
  input logic [15:0] main_div,
  input logic [7:0]  comp_code,
  input logic [9:0]  ref_div,
  input logic [11:0] aux_div,
  input logic        main_en,
  input logic        aux_en,
  input logic [7:0]  test_cfg
);
  logic [55:0] outs;
  assign outs = {main_div, comp_code, ref_div, aux_div, main_en, aux_en, test_cfg};

  // R2
  msb_first_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sreg[23:1] == $past(sreg[22:0]));

  // R3
  strobe_freezes_sreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_lvl |=> $stable(sreg));

  // R4
  no_commit_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> $stable(outs));

  // R6
  b_word_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && sreg[23:22] == 2'b01) |=> $stable(comp_code) && main_en == $past(sreg[13]) && aux_en == $past(sreg[12]));

  // R7
  comp_moves_only_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && sreg[23:22] != 2'b00) |=> $stable(comp_code) && $stable(main_div));

  // R9
  unused_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && sreg[23:21] == 3'b111) |=> $stable(outs));
endmodule

bind ser_synth_loader ser_synth_loader_chk chk_i (.*);

// File: tb/ser_synth_loader_tb_top.sv
`timescale 1ns/1ps
module ser_synth_loader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_stb = 1'b0, ser_dat = 1'b0;
  logic [15:0] main_div;
  logic [7:0]  comp_code, test_cfg;
  logic [9:0]  ref_div;
  logic [11:0] aux_div;
  logic        main_en, aux_en;

  always #5 clk = ~clk;

  ser_synth_loader dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";

  logic [23:0] m_sr = '0, pend_w = '0;
  logic [7:0]  m_stage = '0;
  int          cnt = 0;
  logic [15:0] e_main = '0;
  logic [7:0]  e_comp = '0, e_test = '0;
  logic [9:0]  e_ref = '0;
  logic [11:0] e_aux = '0;
  logic        e_men = 1'b0, e_aen = 1'b0;

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s %s actual=%0h expected=%0h at %0t", phase, req, nm, act, exp, $time);
    end
  endtask

  task automatic apply(logic [23:0] w);
    case (w[23:22])
      2'b00: begin e_main = w[21:6]; e_comp = m_stage; end
      2'b01: begin m_stage = w[21:14]; e_men = w[13]; e_aen = w[12]; end
      2'b10: begin e_ref = w[21:12]; e_aux = w[11:0]; end
      default: if (!w[21]) e_test = w[7:0];
    endcase
  endtask

  always @(posedge clk) begin
    #2;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) apply(pend_w);
    end
    chk("R7", "main_div", 32'(main_div), 32'(e_main));
    chk("R7", "comp_code", 32'(comp_code), 32'(e_comp));
    chk("R5", "ref_div", 32'(ref_div), 32'(e_ref));
    chk("R5", "aux_div", 32'(aux_div), 32'(e_aux));
    chk("R6", "enables", 32'({main_en, aux_en}), 32'({e_men, e_aen}));
    chk("R8", "test_cfg", 32'(test_cfg), 32'(e_test));
  end

  task automatic clk_bit(logic b);
    @(negedge clk); ser_dat = b; ser_clk = 1'b0;
    repeat (5) @(negedge clk);
    ser_clk = 1'b1;
    if (!ser_stb) m_sr = {m_sr[22:0], b};
    repeat (5) @(negedge clk);
  endtask

  task automatic stb_low();
    @(negedge clk); ser_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); ser_stb = 1'b1;
    pend_w = m_sr; cnt = 3;
    repeat (6) @(negedge clk);
  endtask

  task automatic send(logic [23:0] w);
    stb_low();
    for (int i = 23; i >= 0; i--) clk_bit(w[i]);
    strobe();
  endtask

  task automatic send_coincident(logic [22:0] x, logic last);
    stb_low();
    for (int i = 22; i >= 0; i--) clk_bit(x[i]);
    @(negedge clk); ser_dat = last; ser_clk = 1'b0;
    repeat (5) @(negedge clk);
    ser_clk = 1'b1; ser_stb = 1'b1;
    pend_w = m_sr; cnt = 3;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL %s watchdog actual=running expected=finished", phase);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    phase = "R2";
    send({2'b10, 10'h2A5, 12'h93C});
    phase = "R6";
    send({2'b01, 8'h5A, 1'b1, 1'b0, 12'h000});
    phase = "R7";
    send({2'b00, 16'hBEEF, 6'h3F});
    phase = "R6";
    send({2'b01, 8'hC3, 1'b0, 1'b1, 12'hFFF});
    phase = "R7";
    send({2'b00, 16'h1234, 6'h00});
    phase = "R10";
    send({2'b00, 16'h4321, 6'h2A});
    phase = "R8";
    send({3'b110, 13'h1FFF, 8'hA7});
    phase = "R9";
    send({3'b111, 21'h1FFFFF});
    phase = "R3";
    send({2'b10, 10'h155, 12'hAAA});
    for (int k = 0; k < 4; k++) clk_bit(1'b1);
    stb_low();
    strobe();
    phase = "R4";
    send_coincident({1'b0, 16'h7E81, 6'h15}, 1'b1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule